// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns one memory-operand or branch request into a 16-bit offset and a 20-bit physical address. For data operands it adds together any of a base register (BX or BP), an index register (SI or DI) and a displacement, as the mode code selects. The sum wraps at 16 bits. It then selects a segment register, shifts it left by four bits and adds the offset, and this sum wraps at 20 bits. The segment is chosen by default rules: a BP base uses the stack segment, everything else uses the data segment, and the destination index in a string operation uses the extra segment. An override input can replace the default. For branches it forms a same-segment target from IP plus a displacement, or it takes a new CS:IP pair directly from the request.

The surrounding pipeline presents the register values and the request on one cycle. Results appear on the next cycle, qualified by a valid strobe. A small controller holds the output side in one of two states. `ST_IDLE` means no fresh result. `ST_DONE` means a result is on the outputs this cycle. The transition `ACCEPT` (legal request) leads to `ST_DONE` from either state. The transition `DRAIN` (no legal request) leads from `ST_DONE` back to `ST_IDLE`. In `ST_IDLE` without a legal request the controller stays where it is (`WAIT`).

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the result is invalid and all result outputs are zero. Each request with a legal mode raises `res_valid_o` on exactly the following cycle. Back-to-back requests give back-to-back results, and one cycle without a request lowers `res_valid_o`.
- R2: Mode 0 (direct) gives an offset equal to the displacement.
- R3: Mode 1 (one register) gives an offset equal to the pointer chosen by `ptr_sel_i`, where 0=BX, 1=BP, 2=SI and 3=DI. Mode 2 (register relative) adds the displacement to that pointer.
- R4: Mode 3 (based indexed) adds a base to an index. `ptr_sel_i[0]` picks the base (0=BX, 1=BP) and `ptr_sel_i[1]` picks the index (0=SI, 1=DI). Mode 4 adds the displacement to that sum as well.
- R5: When `disp_short_i` is 1, bits 7:0 of the displacement are sign-extended to 16 bits before they are used, in modes 0, 2, 4 and 5.
- R6: The offset wraps modulo 2^16. The physical address is segment*16 + offset, and it wraps modulo 2^20.
- R7: Without an override, a data mode whose address uses BP takes SS as its segment. Every other data access takes DS.
- R8: In data modes, a set `ovr_valid_i` replaces the default segment with the one coded on `ovr_seg_i`, where 0=ES, 1=CS, 2=SS and 3=DS.
- R9: When `string_i` is set and a data mode uses DI, the segment is ES even if an override is present.
- R10: Mode 5 (near branch) gives offset = IP + displacement in segment CS, with `branch_o` set. The override is ignored.
- R11: Mode 6 (far branch) gives segment `far_cs_i` and offset equal to the full 16-bit displacement, with `branch_o` set.
- R12: Mode 7 is rejected. No valid result follows, and the previous result values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing mode code (0..7) |
| ptr_sel_i | input | 2 | Pointer/base/index select |
| disp_short_i | input | 1 | Sign-extend displacement bits 7:0 |
| string_i | input | 1 | String-operation access |
| ovr_valid_i | input | 1 | Segment override present |
| ovr_seg_i | input | 2 | Override segment code |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| disp_i | input | 16 | Displacement / far target offset |
| ip_i | input | 16 | Current IP |
| cs_i | input | 16 | CS value |
| ds_i | input | 16 | DS value |
| ss_i | input | 16 | SS value |
| es_i | input | 16 | ES value |
| far_cs_i | input | 16 | Far-branch target segment |
| res_valid_o | output | 1 | Result valid |
| ea_o | output | 16 | Effective address / branch IP |
| pa_o | output | 20 | Physical address |
| seg_o | output | 16 | Segment used |
| branch_o | output | 1 | Result is a branch target |

## Verification
Segment choice is where more than one rule can apply to a single request. A BP-based address that carries an override, and a string access through DI that also carries an override, each present two competing segment sources in the same cycle. A branch that arrives with the override asserted is a third case of the same kind. Directed requests build each of these collisions on purpose, with every segment register loaded with a distinct value. The winner is then read from `seg_o` and from the physical address on the cycle after the request.

// File: rtl/sag_pkg.sv
package sag_pkg;
    typedef enum logic [2:0] {
        AM_DIRECT     = 3'd0,
        AM_REG        = 3'd1,
        AM_REGREL     = 3'd2,
        AM_BASEIDX    = 3'd3,
        AM_BASEIDXREL = 3'd4,
        AM_NEAR       = 3'd5,
        AM_FAR        = 3'd6,
        AM_RSVD       = 3'd7
    } mode_t;

    typedef enum logic [1:0] {
        SG_ES = 2'd0,
        SG_CS = 2'd1,
        SG_SS = 2'd2,
        SG_DS = 2'd3
    } seg_code_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_t;
endpackage

// File: rtl/sag_offset.sv
module sag_offset
    import sag_pkg::*;
#(
    parameter int AW = 16
) (
    input  mode_t         mode,
    input  logic [1:0]    ptr_sel,
    input  logic [AW-1:0] bx,
    input  logic [AW-1:0] bp,
    input  logic [AW-1:0] si,
    input  logic [AW-1:0] di,
    input  logic [AW-1:0] disp_eff,
    input  logic [AW-1:0] disp_raw,
    input  logic [AW-1:0] ip,
    output logic [AW-1:0] ea,
    output logic          uses_bp,
    output logic          uses_di
);
    logic [AW-1:0] single_ptr;
    logic [AW-1:0] base_val;
    logic [AW-1:0] index_val;

    always_comb begin
        unique case (ptr_sel)
            2'd0: single_ptr = bx;
            2'd1: single_ptr = bp;
            2'd2: single_ptr = si;
            2'd3: single_ptr = di;
        endcase
        base_val  = ptr_sel[0] ? bp : bx;
        index_val = ptr_sel[1] ? di : si;
    end

    always_comb begin
        ea      = '0;
        uses_bp = 1'b0;
        uses_di = 1'b0;
        unique case (mode)
            AM_DIRECT: ea = disp_eff;
            AM_REG: begin
                ea      = single_ptr;
                uses_bp = (ptr_sel == 2'd1);
                uses_di = (ptr_sel == 2'd3);
            end
            AM_REGREL: begin
                ea      = single_ptr + disp_eff;
                uses_bp = (ptr_sel == 2'd1);
                uses_di = (ptr_sel == 2'd3);
            end
            AM_BASEIDX: begin
                ea      = base_val + index_val;
                uses_bp = ptr_sel[0];
                uses_di = ptr_sel[1];
            end
            AM_BASEIDXREL: begin
                ea      = base_val + index_val + disp_eff;
                uses_bp = ptr_sel[0];
                uses_di = ptr_sel[1];
            end
            AM_NEAR: ea = ip + disp_eff;
            AM_FAR:  ea = disp_raw;
            AM_RSVD: ea = '0;
        endcase
    end
endmodule

// File: rtl/sag_segsel.sv
module sag_segsel
    import sag_pkg::*;
#(
    parameter int AW = 16
) (
    input  mode_t         mode,
    input  logic          uses_bp,
    input  logic          uses_di,
    input  logic          string_op,
    input  logic          ovr_valid,
    input  seg_code_t     ovr_seg,
    input  logic [AW-1:0] cs,
    input  logic [AW-1:0] ds,
    input  logic [AW-1:0] ss,
    input  logic [AW-1:0] es,
    input  logic [AW-1:0] far_cs,
    output logic [AW-1:0] seg,
    output logic          is_branch
);
    logic [AW-1:0] ovr_val;

    always_comb begin
        unique case (ovr_seg)
            SG_ES: ovr_val = es;
            SG_CS: ovr_val = cs;
            SG_SS: ovr_val = ss;
            SG_DS: ovr_val = ds;
        endcase
    end

    always_comb begin
        is_branch = 1'b0;
        unique case (mode)
            AM_NEAR: begin
                seg       = cs;
                is_branch = 1'b1;
            end
            AM_FAR: begin
                seg       = far_cs;
                is_branch = 1'b1;
            end
            AM_RSVD: seg = '0;
            default: begin
                if (string_op && uses_di)
                    seg = es;
                else if (ovr_valid)
                    seg = ovr_val;
                else if (uses_bp)
                    seg = ss;
                else
                    seg = ds;
            end
        endcase
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import sag_pkg::*;
#(
    parameter int AW        = 16,
    parameter int SEG_SHIFT = 4,
    parameter int SHORT_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [2:0]              mode_i,
    input  logic [1:0]              ptr_sel_i,
    input  logic                    disp_short_i,
    input  logic                    string_i,
    input  logic                    ovr_valid_i,
    input  logic [1:0]              ovr_seg_i,
    input  logic [AW-1:0]           bx_i,
    input  logic [AW-1:0]           bp_i,
    input  logic [AW-1:0]           si_i,
    input  logic [AW-1:0]           di_i,
    input  logic [AW-1:0]           disp_i,
    input  logic [AW-1:0]           ip_i,
    input  logic [AW-1:0]           cs_i,
    input  logic [AW-1:0]           ds_i,
    input  logic [AW-1:0]           ss_i,
    input  logic [AW-1:0]           es_i,
    input  logic [AW-1:0]           far_cs_i,
    output logic                    res_valid_o,
    output logic [AW-1:0]           ea_o,
    output logic [AW+SEG_SHIFT-1:0] pa_o,
    output logic [AW-1:0]           seg_o,
    output logic                    branch_o
);
    localparam int PAW = AW + SEG_SHIFT;

    mode_t         mode;
    logic          accept;
    logic [AW-1:0] disp_eff;
    logic [AW-1:0] ea_d;
    logic [AW-1:0] seg_d;
    logic          br_d;
    logic          uses_bp;
    logic          uses_di;
    logic [PAW-1:0] pa_d;
    ctl_state_t    state_q, state_d;

    assign mode     = mode_t'(mode_i);
    assign accept   = req_i && (mode != AM_RSVD);
    assign disp_eff = disp_short_i
                    ? {{(AW-SHORT_W){disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]}
                    : disp_i;

    sag_offset #(.AW(AW)) u_off (
        .mode     (mode),
        .ptr_sel  (ptr_sel_i),
        .bx       (bx_i),
        .bp       (bp_i),
        .si       (si_i),
        .di       (di_i),
        .disp_eff (disp_eff),
        .disp_raw (disp_i),
        .ip       (ip_i),
        .ea       (ea_d),
        .uses_bp  (uses_bp),
        .uses_di  (uses_di)
    );

    sag_segsel #(.AW(AW)) u_seg (
        .mode      (mode),
        .uses_bp   (uses_bp),
        .uses_di   (uses_di),
        .string_op (string_i),
        .ovr_valid (ovr_valid_i),
        .ovr_seg   (seg_code_t'(ovr_seg_i)),
        .cs        (cs_i),
        .ds        (ds_i),
        .ss        (ss_i),
        .es        (es_i),
        .far_cs    (far_cs_i),
        .seg       (seg_d),
        .is_branch (br_d)
    );

    assign pa_d = {seg_d, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ea_d};

    // controller: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = accept ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = accept ? ST_DONE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o     <= '0;
            pa_o     <= '0;
            seg_o    <= '0;
            branch_o <= 1'b0;
        end else if (accept) begin
            ea_o     <= ea_d;
            pa_o     <= pa_d;
            seg_o    <= seg_d;
            branch_o <= br_d;
        end
    end

    assign res_valid_o = (state_q == ST_DONE);

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(req_i) && ($past(mode_i) != 3'd7));

    // R12
    rsvd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 3'd7) |=> !res_valid_o && $stable(ea_o) && $stable(pa_o));

    // R6
    pa_compose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> pa_o == (({4'b0, seg_o} << SEG_SHIFT) + {4'b0, ea_o}));

    // R9
    string_es_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && string_i && uses_di && mode_i <= 3'd4) |=> seg_o == $past(es_i));

    // R10
    near_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mode_i == 3'd5) |=> seg_o == $past(cs_i) && branch_o);
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [1:0]  ptr_sel_i = '0;
    logic        disp_short_i = 1'b0;
    logic        string_i = 1'b0;
    logic        ovr_valid_i = 1'b0;
    logic [1:0]  ovr_seg_i = '0;
    logic [15:0] bx_i = 16'h2000, bp_i = 16'h5000, si_i = 16'h3000, di_i = 16'h4000;
    logic [15:0] disp_i = '0, ip_i = 16'h7000;
    logic [15:0] cs_i = 16'h0000, ds_i = 16'h1000, ss_i = 16'h2000, es_i = 16'h3000;
    logic [15:0] far_cs_i = 16'h5000;
    logic        res_valid_o;
    logic [15:0] ea_o;
    logic [19:0] pa_o;
    logic [15:0] seg_o;
    logic        branch_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    seg_addr_gen u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one request, then look at the result one cycle later
    task automatic issue(input logic [2:0] m, input logic [1:0] p, input logic [15:0] d,
                         input logic sh, input logic st, input logic ov, input logic [1:0] os);
        @(negedge clk);
        req_i = 1'b1; mode_i = m; ptr_sel_i = p; disp_i = d;
        disp_short_i = sh; string_i = st; ovr_valid_i = ov; ovr_seg_i = os;
        @(negedge clk);
        req_i = 1'b0; ovr_valid_i = 1'b0; string_i = 1'b0; disp_short_i = 1'b0;
    endtask

    task automatic expect_res(input string tag, input logic [15:0] ea, input logic [19:0] pa,
                              input logic [15:0] seg, input logic br);
        chk({tag, " valid"}, {31'd0, res_valid_o}, 32'd1);
        chk({tag, " ea"}, {16'd0, ea_o}, {16'd0, ea});
        chk({tag, " pa"}, {12'd0, pa_o}, {12'd0, pa});
        chk({tag, " seg"}, {16'd0, seg_o}, {16'd0, seg});
        chk({tag, " br"}, {31'd0, branch_o}, {31'd0, br});
    endtask

    task automatic t_reset();
        chk("R1 reset valid", {31'd0, res_valid_o}, 32'd0);
        chk("R1 reset pa", {12'd0, pa_o}, 32'd0);
        chk("R1 reset ea", {16'd0, ea_o}, 32'd0);
    endtask

    task automatic t_direct();
        issue(3'd0, 2'd0, 16'h5000, 0, 0, 0, 0);
        expect_res("R2 direct", 16'h5000, 20'h15000, 16'h1000, 0);
    endtask

    task automatic t_single();
        issue(3'd1, 2'd0, 16'h0000, 0, 0, 0, 0);
        expect_res("R3 ind BX", 16'h2000, 20'h12000, 16'h1000, 0);
        issue(3'd1, 2'd2, 16'h0000, 0, 0, 0, 0);
        expect_res("R3 ind SI", 16'h3000, 20'h13000, 16'h1000, 0);
        issue(3'd2, 2'd0, 16'h5000, 0, 0, 0, 0);
        expect_res("R3 rel BX", 16'h7000, 20'h17000, 16'h1000, 0);
    endtask

    task automatic t_based();
        issue(3'd3, 2'd0, 16'h0000, 0, 0, 0, 0);
        expect_res("R4 BX+SI", 16'h5000, 20'h15000, 16'h1000, 0);
        issue(3'd4, 2'd0, 16'h5000, 0, 0, 0, 0);
        expect_res("R4 BX+SI+d", 16'hA000, 20'h1A000, 16'h1000, 0);
    endtask

    task automatic t_default_seg();
        issue(3'd1, 2'd1, 16'h0000, 0, 0, 0, 0);
        expect_res("R7 BP ind", 16'h5000, 20'h25000, 16'h2000, 0);
        issue(3'd3, 2'd3, 16'h0000, 0, 0, 0, 0);
        expect_res("R7 BP+DI", 16'h9000, 20'h29000, 16'h2000, 0);
    endtask

    task automatic t_short();
        issue(3'd2, 2'd0, 16'hAAF0, 1, 0, 0, 0);
        expect_res("R5 short neg", 16'h1FF0, 20'h11FF0, 16'h1000, 0);
        issue(3'd2, 2'd0, 16'hAA10, 1, 0, 0, 0);
        expect_res("R5 short pos", 16'h2010, 20'h12010, 16'h1000, 0);
    endtask

    task automatic t_wrap();
        bx_i = 16'hFFFF; si_i = 16'h0002;
        issue(3'd3, 2'd0, 16'h0000, 0, 0, 0, 0);
        expect_res("R6 ea wrap", 16'h0001, 20'h10001, 16'h1000, 0);
        bx_i = 16'h2000; si_i = 16'h3000; ds_i = 16'hFFFF;
        issue(3'd0, 2'd0, 16'h0020, 0, 0, 0, 0);
        expect_res("R6 pa wrap", 16'h0020, 20'h00010, 16'hFFFF, 0);
        ds_i = 16'h1000;
    endtask

    task automatic t_override();
        issue(3'd3, 2'd1, 16'h0000, 0, 0, 1, 2'd3);
        expect_res("R8 BP ovr DS", 16'h8000, 20'h18000, 16'h1000, 0);
        issue(3'd0, 2'd0, 16'h0100, 0, 0, 1, 2'd0);
        expect_res("R8 ovr ES", 16'h0100, 20'h30100, 16'h3000, 0);
    endtask

    task automatic t_string();
        issue(3'd1, 2'd3, 16'h0000, 0, 1, 1, 2'd1);
        expect_res("R9 str DI", 16'h4000, 20'h34000, 16'h3000, 0);
        issue(3'd1, 2'd2, 16'h0000, 0, 1, 0, 0);
        expect_res("R9 str SI", 16'h3000, 20'h13000, 16'h1000, 0);
    endtask

    task automatic t_near();
        issue(3'd5, 2'd0, 16'h0002, 0, 0, 1, 2'd3);
        expect_res("R10 near", 16'h7002, 20'h07002, 16'h0000, 1);
        issue(3'd5, 2'd0, 16'h00FE, 1, 0, 0, 0);
        expect_res("R10 short", 16'h6FFE, 20'h06FFE, 16'h0000, 1);
    endtask

    task automatic t_far();
        issue(3'd6, 2'd0, 16'h0002, 0, 0, 0, 0);
        expect_res("R11 far", 16'h0002, 20'h50002, 16'h5000, 1);
    endtask

    task automatic t_rsvd();
        issue(3'd0, 2'd0, 16'h1234, 0, 0, 0, 0);
        issue(3'd7, 2'd0, 16'h5555, 0, 0, 0, 0);
        chk("R12 no valid", {31'd0, res_valid_o}, 32'd0);
        chk("R12 ea kept", {16'd0, ea_o}, 32'h1234);
        chk("R12 pa kept", {12'd0, pa_o}, 32'h11234);
    endtask

    task automatic t_stream();
        @(negedge clk);
        req_i = 1'b1; mode_i = 3'd0; disp_i = 16'h0001;
        @(negedge clk);
        chk("R1 b2b first", {16'd0, ea_o}, 32'h0001);
        disp_i = 16'h0002;
        @(negedge clk);
        req_i = 1'b0;
        chk("R1 b2b valid", {31'd0, res_valid_o}, 32'd1);
        chk("R1 b2b second", {16'd0, ea_o}, 32'h0002);
        @(negedge clk);
        chk("R1 drain", {31'd0, res_valid_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_single();
        t_based();
        t_default_seg();
        t_short();
        t_wrap();
        t_override();
        t_string();
        t_near();
        t_far();
        t_rsvd();
        t_stream();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule